// File: doc/BRIEF.md
# Address Relocation and Bounds Guard

This unit sits on the path from a processor to memory and vets each processor-generated address before the memory system sees it. A two-bit mode register picks one of three protection schemes. A fence scheme lets user code reach only addresses above a single boundary. A static window admits only addresses strictly inside a lower and an upper bound and leaves them untranslated. A relocating window compares the address with a limit and then adds a per-process base to form the physical address.

Kernel-mode requests skip every check and leave untranslated. The six configuration registers are written through a small write port that only kernel mode may use. An operating system reloads them from the saved state of the incoming process on each context switch. A failed check or a user-mode register write raises a trap with a two-bit cause code. The verdict, the physical address and the trap are registered, so they appear one clock after the request.

Top module: `relguard_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, accept, trap, cause and physical address are all zero. Reset sets the mode to fence (00) and clears the fence, lower, upper, base and limit registers.
- R2: Every result appears on the outputs exactly one clock after the request or write that caused it. A cycle with no request and no register write yields accept 0, trap 0, cause 00 and address 0 one clock later.
- R3: A request with the kernel flag set is accepted in every mode, and the physical address equals the request address.
- R4: In fence mode, a user request is accepted untranslated only if its address is strictly greater than the fence value. Otherwise it traps with cause 01.
- R5: In static mode, a user request is accepted untranslated only if lower < address < upper. An address at or below lower traps with cause 01. Otherwise, an address at or above upper traps with cause 10. The lower test is reported first.
- R6: In relocating mode, a user address strictly below the limit is accepted with physical address = (base + address) mod 2^AW. An address at or above the limit traps with cause 10. The limit is compared with the untranslated address.
- R7: A write with the kernel flag set loads wdata into the register that the select code names: 0 mode (low two bits), 1 fence, 2 lower, 3 upper, 4 base, 5 limit. Codes 6 and 7 change nothing. A request in the same cycle still sees the old values, and the new value governs from the next cycle on.
- R8: A write with the kernel flag clear changes no register and traps with cause 11 one clock later. A request in the same cycle is not accepted.
- R9: The mode encoding is 00 fence, 01 static, and 10 or 11 relocating. Only the checks of the selected mode apply.
- R10: Accept and trap are never high together. Cause is 00 exactly when trap is low, and the physical address is zero whenever accept is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kernel_mode | input | 1 | Privilege of the current request and write: 1 kernel, 0 user |
| req_valid | input | 1 | Address request present |
| req_addr | input | AW | Processor-generated address |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | AW | Register write data |
| accept_o | output | 1 | Request accepted; memory access may proceed |
| phys_addr_o | output | AW | Physical address of an accepted request |
| trap_o | output | 1 | Protection or privilege trap |
| cause_o | output | 2 | Trap cause: 00 none, 01 low, 10 high, 11 privilege |

## Verification
Every output is due exactly one clock after the request or write that produced it, and this holds for configuration writes and their privilege traps as well as for address checks. The bench changes inputs on the falling edge and samples the outputs on the next falling edge, so each check reads the value registered at the one rising edge in between. Because of that spacing, a write followed by a request in the next row shows the new register value taking effect. A write and a request in the same row show that the request was judged against the old value.

// File: rtl/relguard_pkg.sv
package relguard_pkg;
  localparam int SEL_W = 3;
  localparam int CAUSE_W = 2;
  localparam int NBANK = 5;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 2'b00;
  localparam logic [CAUSE_W-1:0] CAUSE_LOW  = 2'b01;
  localparam logic [CAUSE_W-1:0] CAUSE_HIGH = 2'b10;
  localparam logic [CAUSE_W-1:0] CAUSE_PRIV = 2'b11;

  localparam logic [1:0] MODE_FENCE  = 2'b00;
  localparam logic [1:0] MODE_STATIC = 2'b01;

  localparam logic [SEL_W-1:0] SEL_MODE  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_FENCE = 3'd1;
  localparam logic [SEL_W-1:0] SEL_LOWER = 3'd2;
  localparam logic [SEL_W-1:0] SEL_UPPER = 3'd3;
  localparam logic [SEL_W-1:0] SEL_BASE  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_LIMIT = 3'd5;

  // Mode bit 1 selects the relocating window regardless of bit 0.
  function automatic logic mode_relocates(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/relguard_regs.sv
module relguard_regs
  import relguard_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_kernel,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [AW-1:0]    wr_data,
  output logic [1:0]       mode_o,
  output logic [AW-1:0]    fence_o,
  output logic [AW-1:0]    lower_o,
  output logic [AW-1:0]    upper_o,
  output logic [AW-1:0]    base_o,
  output logic [AW-1:0]    limit_o,
  output logic             priv_fault_o
);
  logic          wr_ok;
  logic [1:0]    mode_q;
  logic [AW-1:0] bank_q [NBANK];

  assign wr_ok        = wr_en &  wr_kernel;
  assign priv_fault_o = wr_en & ~wr_kernel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mode_q <= MODE_FENCE;
    else if (wr_ok && wr_sel == SEL_MODE) mode_q <= wr_data[1:0];
  end

  // Bank entry g answers to select code g+1 (fence, lower, upper, base, limit).
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  bank_q[g] <= '0;
      else if (wr_ok && wr_sel == SEL_W'(g + 1))   bank_q[g] <= wr_data;
    end
  end

  assign mode_o  = mode_q;
  assign fence_o = bank_q[SEL_FENCE - 1];
  assign lower_o = bank_q[SEL_LOWER - 1];
  assign upper_o = bank_q[SEL_UPPER - 1];
  assign base_o  = bank_q[SEL_BASE  - 1];
  assign limit_o = bank_q[SEL_LIMIT - 1];

  // R8: a user-mode write leaves every register as it was.
  assert_user_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault_o |=> ($stable(mode_o) && $stable(fence_o) && $stable(lower_o) &&
                      $stable(upper_o) && $stable(base_o) && $stable(limit_o)));
endmodule

// File: rtl/relguard_check.sv
module relguard_check
  import relguard_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               kernel,
  input  logic [AW-1:0]      addr,
  input  logic [1:0]         mode,
  input  logic [AW-1:0]      fence,
  input  logic [AW-1:0]      lower,
  input  logic [AW-1:0]      upper,
  input  logic [AW-1:0]      base,
  input  logic [AW-1:0]      limit,
  output logic               pass_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [AW-1:0]      phys_o,
  output logic               below_ev_o,
  output logic               above_ev_o
);
  // Arithmetic kept in functions so each rule reads on its own.
  function automatic logic f_above(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a > b;
  endfunction

  function automatic logic f_under(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a < b;
  endfunction

  function automatic logic [AW-1:0] f_relocate(input logic [AW-1:0] b, input logic [AW-1:0] a);
    logic [AW:0] sum;
    sum = {1'b0, b} + {1'b0, a};
    return sum[AW-1:0];
  endfunction

  logic          is_reloc;
  logic [AW-1:0] reloc_addr;

  assign is_reloc   = mode_relocates(mode);
  assign reloc_addr = f_relocate(base, addr);

  always_comb begin
    below_ev_o = 1'b0;
    above_ev_o = 1'b0;
    phys_o     = addr;
    if (!kernel) begin
      if (is_reloc) begin
        // Limit is judged on the untranslated address.
        above_ev_o = !f_under(addr, limit);
        phys_o     = reloc_addr;
      end else if (mode[0]) begin
        below_ev_o = !f_above(addr, lower);
        above_ev_o = !f_under(addr, upper) && f_above(addr, lower);
      end else begin
        below_ev_o = !f_above(addr, fence);
      end
    end
  end

  assign pass_o  = !below_ev_o && !above_ev_o;
  assign cause_o = below_ev_o ? CAUSE_LOW : (above_ev_o ? CAUSE_HIGH : CAUSE_NONE);
endmodule

// File: rtl/relguard_unit.sv
module relguard_unit
  import relguard_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               kernel_mode,
  input  logic               req_valid,
  input  logic [AW-1:0]      req_addr,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [AW-1:0]      cfg_wdata,
  output logic               accept_o,
  output logic [AW-1:0]      phys_addr_o,
  output logic               trap_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [1:0]         reg_mode;
  logic [AW-1:0]      reg_fence, reg_lower, reg_upper, reg_base, reg_limit;
  logic               priv_ev;
  logic               chk_pass, below_ev, above_ev;
  logic [CAUSE_W-1:0] chk_cause;
  logic [AW-1:0]      chk_phys;
  logic               ok_ev, fail_ev;

  relguard_regs #(.AW(AW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_we),
    .wr_kernel    (kernel_mode),
    .wr_sel       (cfg_sel),
    .wr_data      (cfg_wdata),
    .mode_o       (reg_mode),
    .fence_o      (reg_fence),
    .lower_o      (reg_lower),
    .upper_o      (reg_upper),
    .base_o       (reg_base),
    .limit_o      (reg_limit),
    .priv_fault_o (priv_ev)
  );

  relguard_check #(.AW(AW)) u_check (
    .kernel     (kernel_mode),
    .addr       (req_addr),
    .mode       (reg_mode),
    .fence      (reg_fence),
    .lower      (reg_lower),
    .upper      (reg_upper),
    .base       (reg_base),
    .limit      (reg_limit),
    .pass_o     (chk_pass),
    .cause_o    (chk_cause),
    .phys_o     (chk_phys),
    .below_ev_o (below_ev),
    .above_ev_o (above_ev)
  );

  // A privilege fault outranks the address verdict of the same cycle.
  assign ok_ev   = req_valid &  chk_pass & ~priv_ev;
  assign fail_ev = req_valid & ~chk_pass & ~priv_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_o    <= 1'b0;
      trap_o      <= 1'b0;
      cause_o     <= CAUSE_NONE;
      phys_addr_o <= '0;
    end else begin
      accept_o    <= ok_ev;
      trap_o      <= fail_ev | priv_ev;
      cause_o     <= priv_ev ? CAUSE_PRIV : (fail_ev ? chk_cause : CAUSE_NONE);
      phys_addr_o <= ok_ev ? chk_phys : '0;
    end
  end

  assert_accept_trap_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_o && trap_o));

  assert_cause_matches_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o == (cause_o != CAUSE_NONE));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !priv_ev) |=> (!accept_o && !trap_o && phys_addr_o == '0));

  assert_priv_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    priv_ev |=> (trap_o && cause_o == CAUSE_PRIV && !accept_o));

  assert_kernel_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kernel_mode) |=> (accept_o && phys_addr_o == $past(req_addr)));

  assert_fence_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !kernel_mode && reg_mode == MODE_FENCE && req_addr <= reg_fence)
      |=> (trap_o && cause_o == CAUSE_LOW));

  assert_reloc_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !kernel_mode && !priv_ev && reg_mode[1] && req_addr < reg_limit)
      |=> (accept_o && phys_addr_o == AW'($past(reg_base) + $past(req_addr))));

  assert_static_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !kernel_mode && !priv_ev && reg_mode == MODE_STATIC && above_ev)
      |=> (trap_o && cause_o == CAUSE_HIGH));

  assert_low_event_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !priv_ev && below_ev) |=> (cause_o == CAUSE_LOW));
endmodule

// File: tb/relguard_unit_bench.sv
`timescale 1ns/1ps
module relguard_unit_bench;
  localparam int AW = 16;
  localparam int NV = 34;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          kernel_mode = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          accept_o;
  logic [AW-1:0] phys_addr_o;
  logic          trap_o;
  logic [1:0]    cause_o;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  relguard_unit #(.AW(AW)) u_relguard_unit (
    .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode), .req_valid(req_valid),
    .req_addr(req_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .accept_o(accept_o), .phys_addr_o(phys_addr_o), .trap_o(trap_o), .cause_o(cause_o)
  );

  // Row: {kern, we, sel[3], wdata[16], req, addr[16], acc, trap, cause[2], phys[16], rid[4]}
  localparam logic [61:0] VEC [NV] = '{
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0010, 1'b1,1'b0,2'd0,16'h0010, 4'd4}, // R4 above fence 0
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0000, 1'b0,1'b1,2'd1,16'h0000, 4'd4}, // R4 equal fails
    {1'b1,1'b1,3'd1,16'h1000,1'b0,16'h0000, 1'b0,1'b0,2'd0,16'h0000, 4'd7}, // R7 fence
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h1000, 1'b0,1'b1,2'd1,16'h0000, 4'd4}, // R4
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h1001, 1'b1,1'b0,2'd0,16'h1001, 4'd4}, // R4
    {1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0004, 1'b1,1'b0,2'd0,16'h0004, 4'd3}, // R3
    {1'b1,1'b1,3'd2,16'h2000,1'b0,16'h0000, 1'b0,1'b0,2'd0,16'h0000, 4'd7}, // R7 lower
    {1'b1,1'b1,3'd3,16'h3000,1'b0,16'h0000, 1'b0,1'b0,2'd0,16'h0000, 4'd7}, // R7 upper
    {1'b1,1'b1,3'd0,16'h0001,1'b0,16'h0000, 1'b0,1'b0,2'd0,16'h0000, 4'd9}, // R9 static
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h2000, 1'b0,1'b1,2'd1,16'h0000, 4'd5}, // R5 at lower
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h2001, 1'b1,1'b0,2'd0,16'h2001, 4'd5}, // R5
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h2FFF, 1'b1,1'b0,2'd0,16'h2FFF, 4'd5}, // R5
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h3000, 1'b0,1'b1,2'd2,16'h0000, 4'd5}, // R5 at upper
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h1800, 1'b0,1'b1,2'd1,16'h0000, 4'd9}, // R9 fence unused
    {1'b1,1'b1,3'd4,16'h8000,1'b0,16'h0000, 1'b0,1'b0,2'd0,16'h0000, 4'd7}, // R7 base
    {1'b1,1'b1,3'd5,16'h0100,1'b0,16'h0000, 1'b0,1'b0,2'd0,16'h0000, 4'd7}, // R7 limit
    {1'b1,1'b1,3'd0,16'h0002,1'b0,16'h0000, 1'b0,1'b0,2'd0,16'h0000, 4'd9}, // R9 reloc
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h00FF, 1'b1,1'b0,2'd0,16'h80FF, 4'd6}, // R6
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0100, 1'b0,1'b1,2'd2,16'h0000, 4'd6}, // R6 at limit
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0000, 1'b1,1'b0,2'd0,16'h8000, 4'd6}, // R6
    {1'b0,1'b1,3'd4,16'h1234,1'b0,16'h0000, 1'b0,1'b1,2'd3,16'h0000, 4'd8}, // R8
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0010, 1'b1,1'b0,2'd0,16'h8010, 4'd8}, // R8 base kept
    {1'b0,1'b1,3'd5,16'h0000,1'b1,16'h0010, 1'b0,1'b1,2'd3,16'h0000, 4'd8}, // R8 blocks req
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0010, 1'b1,1'b0,2'd0,16'h8010, 4'd8}, // R8 limit kept
    {1'b1,1'b1,3'd0,16'h0003,1'b0,16'h0000, 1'b0,1'b0,2'd0,16'h0000, 4'd9}, // R9 mode 11
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0020, 1'b1,1'b0,2'd0,16'h8020, 4'd9}, // R9
    {1'b1,1'b1,3'd4,16'hFF80,1'b0,16'h0000, 1'b0,1'b0,2'd0,16'h0000, 4'd7}, // R7
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h00F0, 1'b1,1'b0,2'd0,16'h0070, 4'd6}, // R6 wraps
    {1'b1,1'b0,3'd0,16'h0000,1'b1,16'h00F0, 1'b1,1'b0,2'd0,16'h00F0, 4'd3}, // R3 reloc mode
    {1'b0,1'b0,3'd0,16'h0000,1'b0,16'h0000, 1'b0,1'b0,2'd0,16'h0000, 4'd2}, // R2 idle
    {1'b1,1'b1,3'd5,16'h0010,1'b0,16'h0000, 1'b0,1'b0,2'd0,16'h0000, 4'd7}, // R7
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0010, 1'b0,1'b1,2'd2,16'h0000, 4'd7}, // R7 new limit
    {1'b1,1'b1,3'd4,16'h0000,1'b1,16'h0005, 1'b1,1'b0,2'd0,16'h0005, 4'd3}, // R3 with write
    {1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0005, 1'b1,1'b0,2'd0,16'h0005, 4'd7}  // R7 base now 0
  };

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic acc, input logic trp,
                           input logic [1:0] cs, input logic [AW-1:0] ph);
    check(tag, "accept", 32'(accept_o), 32'(acc));
    check(tag, "trap", 32'(trap_o), 32'(trp));
    check(tag, "cause", 32'(cause_o), 32'(cs));
    check(tag, "phys", 32'(phys_addr_o), 32'(ph));
  endtask

  task automatic idle();
    kernel_mode = 1'b0; cfg_we = 1'b0; req_valid = 1'b0;
    cfg_sel = '0; cfg_wdata = '0; req_addr = '0;
  endtask

  task automatic user_req(input logic [AW-1:0] a);
    kernel_mode = 1'b0; cfg_we = 1'b0; req_valid = 1'b1; req_addr = a;
    @(negedge clk);
  endtask

  // Relocating-window expectation restated from R6.
  function automatic logic [AW-1:0] exp_reloc(input logic [AW-1:0] b, input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = b + a;
    return r;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog R2 actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check_all("R1 in reset", 1'b0, 1'b0, 2'd0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset", 1'b0, 1'b0, 2'd0, '0);
    user_req(16'h0000);
    check_all("R1 fence cleared", 1'b0, 1'b1, 2'd1, '0);
    user_req(16'h0001);
    check_all("R1 fence mode", 1'b1, 1'b0, 2'd0, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      logic [61:0] v;
      v = VEC[i];
      kernel_mode = v[61]; cfg_we = v[60]; cfg_sel = v[59:57]; cfg_wdata = v[56:41];
      req_valid = v[40]; req_addr = v[39:24];
      @(negedge clk);
      check_all($sformatf("R%0d row %0d", v[3:0], i), v[23], v[22], v[21:20], v[19:4]);
    end
    idle();

    // R6 sweep around limit: base 0x0000, limit 0x0010, then a non-zero base.
    for (int a = 12; a < 20; a++) begin
      user_req(AW'(a));
      if (a < 16) check_all("R6 sweep", 1'b1, 1'b0, 2'd0, exp_reloc(16'h0000, AW'(a)));
      else        check_all("R6 sweep", 1'b0, 1'b1, 2'd2, '0);
    end
    kernel_mode = 1'b1; cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 16'hFFF8; req_valid = 1'b0;
    @(negedge clk);
    for (int a = 6; a < 10; a++) begin
      user_req(AW'(a));
      check_all("R6 wrap sweep", 1'b1, 1'b0, 2'd0, exp_reloc(16'hFFF8, AW'(a)));
    end

    // R7: unused select code 6 changes nothing visible.
    kernel_mode = 1'b1; cfg_we = 1'b1; cfg_sel = 3'd6; cfg_wdata = 16'hFFFF; req_valid = 1'b0;
    @(negedge clk);
    check_all("R7 sel6 quiet", 1'b0, 1'b0, 2'd0, '0);
    user_req(16'h0003);
    check_all("R7 sel6 ignored", 1'b1, 1'b0, 2'd0, 16'hFFFB);

    // R5: lower >= upper, the lower failure is reported.
    kernel_mode = 1'b1; cfg_we = 1'b1; cfg_sel = 3'd2; cfg_wdata = 16'h5000; @(negedge clk);
    cfg_sel = 3'd3; cfg_wdata = 16'h4000; @(negedge clk);
    cfg_sel = 3'd0; cfg_wdata = 16'h0001; @(negedge clk);
    user_req(16'h4800);
    check_all("R5 low first", 1'b0, 1'b1, 2'd1, '0);
    user_req(16'h5800);
    check_all("R5 high", 1'b0, 1'b1, 2'd2, '0);

    // R1: reset in mid-run restores fence mode with zero registers.
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1 mid reset", 1'b0, 1'b0, 2'd0, '0);
    rst_n = 1'b1;
    user_req(16'h4800);
    check_all("R1 regs cleared", 1'b1, 1'b0, 2'd0, 16'h4800);
    idle();
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule